// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Flags

This block sits beside the time-of-day counters of a real-time clock. Each time the counters signal that an update has completed, it compares the freshly advanced seconds, minutes and hours bytes with three alarm bytes. A hit latches the alarm flag in the interrupt status byte.

The status byte also holds an update-ended flag and a periodic flag. Other blocks produce the events behind those two flags; this block only latches them. Three enable inputs select which latched flags drive the interrupt line.

Software reads the status byte through a single read strobe. The read returns the current flags and empties the byte. Any event arriving in that same cycle is kept for the following read.

Top module: `rtc_alarm_flags`

## Requirements
- R1: An alarm byte whose two most significant bits are both 1 (values 0xC0 to 0xFF) matches every value of its time field.
- R2: Any other alarm byte must equal its time byte in all eight bits. The hour bit 7 (PM in 12-hour mode) is included, so alarm 0x82 does not match hour 0x02, and alarm 0x02 does not match hour 0x82.
- R3: The alarm flag (status bit 5) is set only on a cycle with `upd_strobe` high in which all three fields match. It then stays set until a status read.
- R4: The update-ended flag (status bit 4) is set by every `upd_strobe`. The periodic flag (status bit 6) is set by every `periodic_evt`.
- R5: `regc_rdata` shows bit 7 as the summary interrupt bit, bits 6..4 as the periodic, alarm and update-ended flags, and bits 3..0 as zero. A cycle with `rd_strobe` high returns the current value, and the clock edge that ends that cycle clears every flag.
- R6: An event that sets a flag in the same cycle as a status read is kept and appears in the next read.
- R7: `irq_o` and status bit 7 are high exactly when at least one latched flag has its enable input high. They respond to an enable change in the same cycle, and to a flag event after one clock edge.
- R8: After reset all flags are clear, `regc_rdata` is 0x00 and `irq_o` is low.
- R9: Flags latch whatever the enable inputs are. A flag with its enable low does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_strobe | input | 1 | One-cycle pulse: time counters have finished advancing |
| periodic_evt | input | 1 | One-cycle pulse from the periodic rate generator |
| rd_strobe | input | 1 | Status byte is read in this cycle |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| time_now | input | 24 | Current time {hours, minutes, seconds}, one byte each |
| alarm_set | input | 24 | Alarm bytes {hours, minutes, seconds} |
| regc_rdata | output | 8 | Status byte contents |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A flag set by `upd_strobe` or `periodic_evt` shows in `regc_rdata` and in `irq_o` one clock edge after the strobe cycle. A change of an enable input reaches `irq_o` and status bit 7 in the same cycle. A read returns its value during the strobe cycle, and the cleared byte shows after the following edge. The bench drives every input on the falling clock edge. It samples read data 1 ns after raising the read strobe, and it checks results from an event 1 ns after the next falling edge, when exactly one rising edge has passed.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_FIELDS = 3;

  typedef struct packed {
    logic periodic;
    logic alarm;
    logic update;
  } rtc_flags_t;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_field_match.sv
module rtc_field_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_val,
  input  logic [W-1:0] alm_val,
  output logic         hit
);
  localparam logic [1:0] WILD_CODE = 2'b11;

  logic wild;

  always_comb begin
    wild = (alm_val[W-1 -: 2] == WILD_CODE);
    hit  = wild || (alm_val == cur_val);
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_strobe,
  input  logic       periodic_evt,
  input  logic       all_hit,
  input  logic       rd_strobe,
  output rtc_flags_t flags_q
);
  rtc_flags_t flags_d;
  rtc_flags_t set_vec;
  rtc_flags_t kept;

  always_comb begin
    set_vec.periodic = periodic_evt;
    set_vec.alarm    = upd_strobe & all_hit;
    set_vec.update   = upd_strobe;
    kept             = rd_strobe ? '0 : flags_q;
    flags_d          = kept | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned W       = BYTE_W,
  parameter int unsigned NFIELDS = N_FIELDS,
  localparam int unsigned TW     = W * NFIELDS,
  localparam int unsigned PAD_W  = W - 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_strobe,
  input  logic          periodic_evt,
  input  logic          rd_strobe,
  input  logic          en_periodic,
  input  logic          en_alarm,
  input  logic          en_update,
  input  logic [TW-1:0] time_now,
  input  logic [TW-1:0] alarm_set,
  output logic [W-1:0]  regc_rdata,
  output logic          irq_o
);
  logic               rst_sync_n;
  logic [NFIELDS-1:0] field_hit;
  logic               all_hit;
  rtc_flags_t         flags_q;
  rtc_flags_t         enables;
  logic               irq_sum;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    rtc_field_match #(.W(W)) u_cmp (
      .cur_val (time_now[f*W +: W]),
      .alm_val (alarm_set[f*W +: W]),
      .hit     (field_hit[f])
    );
  end

  rtc_flag_reg u_flags (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .upd_strobe   (upd_strobe),
    .periodic_evt (periodic_evt),
    .all_hit      (all_hit),
    .rd_strobe    (rd_strobe),
    .flags_q      (flags_q)
  );

  always_comb begin
    all_hit          = &field_hit;
    enables.periodic = en_periodic;
    enables.alarm    = en_alarm;
    enables.update   = en_update;
    irq_sum          = |(flags_q & enables);
    regc_rdata       = {irq_sum, flags_q, {PAD_W{1'b0}}};
    irq_o            = irq_sum;
  end
endmodule

// File: rtl/rtc_alarm_flags_chk.sv
module rtc_alarm_flags_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned TW = 24
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          upd_strobe,
  input logic          periodic_evt,
  input logic          rd_strobe,
  input logic          en_periodic,
  input logic          en_alarm,
  input logic          en_update,
  input logic [TW-1:0] time_now,
  input logic [TW-1:0] alarm_set,
  input logic [W-1:0]  regc_rdata,
  input logic          irq_o
);
  localparam int unsigned NF = TW / W;

  logic ref_hit;
  logic all_wild;

  always_comb begin
    ref_hit  = 1'b1;
    all_wild = 1'b1;
    for (int f = 0; f < NF; f++) begin
      if (alarm_set[f*W + W-1] && alarm_set[f*W + W-2]) begin
        ref_hit = ref_hit;
      end else begin
        all_wild = 1'b0;
        if (alarm_set[f*W +: W] != time_now[f*W +: W]) ref_hit = 1'b0;
      end
    end
  end

  assert_wild_fires_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_strobe && all_wild) |=> regc_rdata[5]);

  assert_match_sets_af_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_strobe && ref_hit) |=> regc_rdata[5]);

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_strobe && !upd_strobe && !periodic_evt) |=> $stable(regc_rdata[6:4]));

  assert_update_sets_uf_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_strobe |=> regc_rdata[4]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_strobe && !upd_strobe && !periodic_evt) |=> (regc_rdata[6:4] == 3'b000));

  assert_same_cycle_kept_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_strobe && periodic_evt) |=> regc_rdata[6]);

  assert_no_enable_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_periodic && !en_alarm && !en_update) |-> !irq_o);
endmodule

bind rtc_alarm_flags rtc_alarm_flags_chk #(.W(W), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .upd_strobe   (upd_strobe),
  .periodic_evt (periodic_evt),
  .rd_strobe    (rd_strobe),
  .en_periodic  (en_periodic),
  .en_alarm     (en_alarm),
  .en_update    (en_update),
  .time_now     (time_now),
  .alarm_set    (alarm_set),
  .regc_rdata   (regc_rdata),
  .irq_o        (irq_o)
);

// File: tb/rtc_alarm_flags_tb.sv
`timescale 1ns/1ps
module rtc_alarm_flags_tb;
  logic        clk;
  logic        rst_n;
  logic        upd_strobe;
  logic        periodic_evt;
  logic        rd_strobe;
  logic        en_periodic;
  logic        en_alarm;
  logic        en_update;
  logic [23:0] time_now;
  logic [23:0] alarm_set;
  logic [7:0]  regc_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_errors = 0;

  rtc_alarm_flags u_dut (
    .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .periodic_evt(periodic_evt),
    .rd_strobe(rd_strobe), .en_periodic(en_periodic), .en_alarm(en_alarm),
    .en_update(en_update), .time_now(time_now), .alarm_set(alarm_set),
    .regc_rdata(regc_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_update(input logic [23:0] cur, input logic [23:0] alm);
    @(negedge clk);
    time_now   = cur;
    alarm_set  = alm;
    upd_strobe = 1'b1;
    @(negedge clk);
    upd_strobe = 1'b0;
    #1;
  endtask

  task automatic do_read(output logic [7:0] val);
    @(negedge clk);
    rd_strobe = 1'b1;
    #1 val = regc_rdata;
    @(negedge clk);
    rd_strobe = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R8 status after reset", regc_rdata, 8'h00);
    chk("R8 irq after reset", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_wildcard;
    logic [7:0] v;
    do_update(24'h12_34_56, 24'hC0_C0_C0);
    do_read(v);
    chk("R1 all-wildcard alarm fires", v, 8'h30);
    do_read(v);
    chk("R5 second read after clear", v, 8'h00);
    do_update(24'h12_07_41, 24'h12_C5_FF);
    do_read(v);
    chk("R1 wildcard C5/FF with exact hour", v, 8'h30);
  endtask

  task automatic t_pm;
    logic [7:0] v;
    do_update(24'h82_00_00, 24'h82_C0_C0);
    do_read(v);
    chk("R2 PM alarm at PM hour", v, 8'h30);
    do_update(24'h82_00_00, 24'h02_C0_C0);
    do_read(v);
    chk("R2 AM alarm at PM hour", v, 8'h10);
    do_update(24'h02_00_00, 24'h82_C0_C0);
    do_read(v);
    chk("R2 PM alarm at AM hour", v, 8'h10);
  endtask

  task automatic t_exact;
    logic [7:0] v;
    do_update(24'h09_15_30, 24'h09_15_30);
    do_read(v);
    chk("R3 exact match", v, 8'h30);
    do_update(24'h09_15_31, 24'h09_15_30);
    do_read(v);
    chk("R3 seconds differ", v, 8'h10);
    @(negedge clk);
    time_now  = 24'h09_15_30;
    alarm_set = 24'h09_15_30;
    repeat (3) @(negedge clk);
    #1 chk("R3 match without update strobe", regc_rdata, 8'h00);
    do_update(24'h09_15_30, 24'h09_15_30);
    repeat (4) @(negedge clk);
    #1 chk("R3 alarm flag held until read", regc_rdata, 8'h30);
    do_read(v);
  endtask

  task automatic t_periodic;
    logic [7:0] v;
    @(negedge clk);
    periodic_evt = 1'b1;
    @(negedge clk);
    periodic_evt = 1'b0;
    #1 chk("R4 periodic flag latched", regc_rdata, 8'h40);
    do_read(v);
    chk("R4 periodic read value", v, 8'h40);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    do_update(24'h01_02_03, 24'h01_02_03);
    chk("R9 flag latched with enables low", regc_rdata, 8'h30);
    chk("R9 irq low with enables low", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    en_alarm = 1'b1;
    #1 chk("R7 irq follows alarm enable", {7'd0, irq_o}, 8'h01);
    chk("R7 summary bit set", regc_rdata, 8'hB0);
    do_read(v);
    chk("R5 read returns summary bit", v, 8'hB0);
    chk("R7 irq drops after read", {7'd0, irq_o}, 8'h00);
    en_alarm  = 1'b0;
    en_update = 1'b1;
    do_update(24'h01_02_04, 24'h01_02_03);
    chk("R7 update interrupt", {irq_o, regc_rdata[6:0]}, 8'h90);
    do_read(v);
    en_update   = 1'b0;
    en_periodic = 1'b1;
    @(negedge clk);
    periodic_evt = 1'b1;
    @(negedge clk);
    periodic_evt = 1'b0;
    #1 chk("R7 periodic interrupt", regc_rdata, 8'hC0);
    do_read(v);
    en_periodic = 1'b0;
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    @(negedge clk);
    time_now   = 24'h05_05_05;
    alarm_set  = 24'h06_05_05;
    rd_strobe  = 1'b1;
    upd_strobe = 1'b1;
    #1 v = regc_rdata;
    chk("R6 read during update returns old value", v, 8'h00);
    @(negedge clk);
    rd_strobe  = 1'b0;
    upd_strobe = 1'b0;
    do_read(v);
    chk("R6 update flag kept across read", v, 8'h10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_strobe = 1'b0; periodic_evt = 1'b0; rd_strobe = 1'b0;
    en_periodic = 1'b0; en_alarm = 1'b0; en_update = 1'b0;
    time_now = '0; alarm_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_wildcard();
    t_pm();
    t_exact();
    t_periodic();
    t_irq();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule